// File: doc/BRIEF.md
# NAND Flash Operation Sequencer

The sequencer runs complete operations on an 8-bit asynchronous NAND flash device on behalf of a host. The host presents one request at a time: an operation code, a 17-bit page number, a 12-bit column offset and a byte count. The sequencer then produces the whole device conversation. It drives the command-latch, address-latch, chip-enable, write-strobe and read-strobe pins. It drives or samples the 8-bit I/O bus and watches the ready/busy line. A one-cycle done pulse marks the end of each request.

Page data moves through a page buffer port. During a program the bytes are fetched from the buffer at addresses 0 upward. During a page read or an ID read the bytes are stored into the buffer at addresses 0 upward. Program and erase finish with a status poll. A failed poll, or a ready/busy wait that runs past a cycle limit, raises a sticky error flag. The flag stays set until the host clears it.

Each operation is one walk through a central state machine. The states are IDLE, CMD1, ADDR, WDATA, CMD2, WAIT_RB, RDATA, STAT_CMD, STAT_RD and FINISH. The transitions are:
- IDLE→CMD1 on a valid request, or IDLE→FINISH on an unknown code.
- CMD1→ADDR, or CMD1→WAIT_RB for a reset.
- ADDR→WDATA, CMD2 or RDATA.
- WDATA→CMD2.
- CMD2→WAIT_RB.
- WAIT_RB→RDATA, STAT_CMD or FINISH on a ready edge, or WAIT_RB→FINISH on a timeout.
- RDATA→FINISH.
- STAT_CMD→STAT_RD.
- STAT_RD→FINISH.
- FINISH→IDLE.

A byte engine under the state machine performs each single bus cycle.

Top module: `nand_seq`

## Requirements
- R1: After reset the block is idle: busy, done and all four error flags are 0; chip-enable, write strobe and read strobe are high.
- R2: Operation codes are 0 reset, 1 read ID, 2 page read, 3 page program and 4 block erase. A request is taken only in IDLE. Busy is 1 from the first cycle after acceptance through the single cycle in which done is 1, and is 0 after that. A request raised while busy is ignored.
- R3: The address bytes go out in this order: column[7:0]; then {4'b0, column[11:8]}; then page[7:0]; then page[15:8]; then {7'b0, page[16]}.
- R4: A page read issues command 0x00, then five address bytes, then command 0x30. It then waits for a ready rising edge and reads the requested count of bytes with the read strobe, storing them at buffer addresses 0 upward.
- R5: A page program issues command 0x80, then five address bytes, then the requested count of data bytes taken from buffer addresses 0 upward. It then issues command 0x10, waits for ready, and issues the status command 0x70 followed by one status read.
- R6: A block erase issues command 0x60, then only the three page bytes, then command 0xD0. It then waits for ready and performs the 0x70 status read.
- R7: A read ID issues command 0x90 with one address byte 0x00. It then reads five bytes into buffer addresses 0 to 4, with no ready/busy wait.
- R8: A reset issues command 0xFF with no address byte, then waits for ready.
- R9: A status byte passes only when bit 6 is 1 and bit 0 is 0. A failing byte sets err_prog after a program and err_erase after an erase.
- R10: If no ready rising edge arrives within TMO_CYC cycles of waiting, the operation ends with done. err_rd_tmo is set for a reset or page read, and err_wr_tmo for a program or erase. No status or data read follows the timeout.
- R11: Error flags are sticky across later operations. A clr_err pulse clears them all by the next cycle.
- R12: Command-latch and address-latch are held unchanged for one cycle before the write strobe falls and one cycle after it rises. They are never high together. Chip-enable is low whenever a strobe is low. The bus is never driven while the read strobe is low.
- R13: An unknown operation code (5 to 7) produces done in the first cycle after acceptance with no device bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken while idle |
| req_op | input | 3 | Operation code |
| req_page | input | 17 | Page (row) number |
| req_col | input | 12 | Column offset |
| req_len | input | clog2(PAGE_BYTES+1) | Data byte count for read and program |
| clr_err | input | 1 | Clears all error flags |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err_rd_tmo | output | 1 | Sticky read-side timeout flag |
| err_wr_tmo | output | 1 | Sticky write-side timeout flag |
| err_prog | output | 1 | Sticky program failure flag |
| err_erase | output | 1 | Sticky erase failure flag |
| buf_addr | output | clog2(PAGE_BYTES) | Page buffer byte address |
| buf_wdata | output | 8 | Byte stored into the buffer |
| buf_we | output | 1 | Buffer store strobe |
| buf_rdata | input | 8 | Buffer byte at buf_addr (combinational) |
| dev_ce_n | output | 1 | Device chip enable, active low |
| dev_cle | output | 1 | Command latch enable |
| dev_ale | output | 1 | Address latch enable |
| dev_we_n | output | 1 | Write strobe, active low |
| dev_re_n | output | 1 | Read strobe, active low |
| dev_io_out | output | 8 | Byte driven onto the device bus |
| dev_io_oe | output | 1 | Bus drive enable |
| dev_io_in | input | 8 | Byte sampled from the device bus |
| dev_rb | input | 1 | Ready (1) / busy (0) |

## Verification
Busy is due at the first sample after the accepting clock edge. For an unknown code, done is also due there. Otherwise done arrives after the last byte-engine cycle and stays high for one sample, and the error flags are already valid in that done cycle. The bench samples all outputs at the falling clock edge: it checks busy and chip-enable at every sample of an operation, and it checks idle at the sample after done. Device-side results are due on write-strobe rising edges and read-strobe cycles. A behavioural flash model logs them there, and the bench compares that log with sequences built from the requirements once done has been seen.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    typedef enum logic [2:0] {
        OP_RESET     = 3'd0,
        OP_READ_ID   = 3'd1,
        OP_PAGE_READ = 3'd2,
        OP_PROGRAM   = 3'd3,
        OP_ERASE     = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        BK_CMD   = 2'd0,
        BK_ADDR  = 2'd1,
        BK_WDATA = 2'd2,
        BK_RDATA = 2'd3
    } bus_kind_e;

    localparam int ROW_W = 17;
    localparam int COL_W = 12;

    localparam logic [7:0] CODE_READ_SETUP = 8'h00;
    localparam logic [7:0] CODE_READ_GO    = 8'h30;
    localparam logic [7:0] CODE_PROG_SETUP = 8'h80;
    localparam logic [7:0] CODE_PROG_GO    = 8'h10;
    localparam logic [7:0] CODE_ERASE_SETUP = 8'h60;
    localparam logic [7:0] CODE_ERASE_GO   = 8'hD0;
    localparam logic [7:0] CODE_IDENT      = 8'h90;
    localparam logic [7:0] CODE_STATUS     = 8'h70;
    localparam logic [7:0] CODE_RESET      = 8'hFF;

    localparam int STAT_READY_BIT = 6;
    localparam int STAT_FAIL_BIT  = 0;
    localparam int ID_BYTES       = 5;

endpackage

// File: rtl/nand_addr_map.sv
module nand_addr_map
    import nand_seq_pkg::*;
(
    input  logic [ROW_W-1:0] page,
    input  logic [COL_W-1:0] col,
    input  logic [2:0]       idx,
    output logic [7:0]       addr_byte
);
    always_comb begin
        unique case (idx)
            3'd0:    addr_byte = col[7:0];
            3'd1:    addr_byte = {4'b0000, col[11:8]};
            3'd2:    addr_byte = page[7:0];
            3'd3:    addr_byte = page[15:8];
            3'd4:    addr_byte = {7'b0000000, page[16]};
            default: addr_byte = 8'h00;
        endcase
    end
endmodule

// File: rtl/nand_wait_timer.sv
module nand_wait_timer #(
    parameter int LIMIT = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int TW = $clog2(LIMIT + 1);

    logic [TW-1:0] cnt;

    assign expired = (cnt == TW'(LIMIT));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (!expired) begin
            cnt <= cnt + TW'(1);
        end
    end
endmodule

// File: rtl/nand_bus_engine.sv
module nand_bus_engine
    import nand_seq_pkg::*;
#(
    parameter int RD_LOW_CYC = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  bus_kind_e kind,
    input  logic [7:0] wbyte,
    output logic      done,
    output logic [7:0] rbyte,
    output logic      cle,
    output logic      ale,
    output logic      we_n,
    output logic      re_n,
    output logic [7:0] io_out,
    output logic      io_oe,
    input  logic [7:0] io_in
);
    localparam int CW = (RD_LOW_CYC > 1) ? $clog2(RD_LOW_CYC) : 1;

    typedef enum logic [2:0] {
        E_IDLE, E_SETUP, E_WLOW, E_HOLD, E_RLOW, E_RHIGH
    } eng_st_e;

    eng_st_e   st, st_nx;
    bus_kind_e kind_q;
    logic [7:0] byte_q;
    logic [CW-1:0] cnt;
    logic rd_last;
    logic wr_phase;

    assign rd_last = (cnt == CW'(RD_LOW_CYC - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= E_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            E_IDLE:  if (start) st_nx = (kind == BK_RDATA) ? E_RLOW : E_SETUP;
            E_SETUP: st_nx = E_WLOW;
            E_WLOW:  st_nx = E_HOLD;
            E_HOLD:  st_nx = E_IDLE;
            E_RLOW:  if (rd_last) st_nx = E_RHIGH;
            E_RHIGH: st_nx = E_IDLE;
            default: st_nx = E_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q <= BK_CMD;
            byte_q <= 8'h00;
            cnt    <= '0;
            rbyte  <= 8'h00;
            done   <= 1'b0;
        end else begin
            if (st == E_IDLE && start) begin
                kind_q <= kind;
                byte_q <= wbyte;
            end
            if (st == E_RLOW) cnt <= cnt + CW'(1);
            else              cnt <= '0;
            if (st == E_RLOW && rd_last) rbyte <= io_in;
            done <= (st == E_HOLD) || (st == E_RHIGH);
        end
    end

    always_comb begin
        wr_phase = (st == E_SETUP) || (st == E_WLOW) || (st == E_HOLD);
        cle      = wr_phase && (kind_q == BK_CMD);
        ale      = wr_phase && (kind_q == BK_ADDR);
        io_oe    = wr_phase;
        io_out   = byte_q;
        we_n     = (st != E_WLOW);
        re_n     = (st != E_RLOW);
    end
endmodule

// File: rtl/nand_seq.sv
module nand_seq
    import nand_seq_pkg::*;
#(
    parameter int PAGE_BYTES = 64,
    parameter int RD_LOW_CYC = 2,
    parameter int TMO_CYC    = 200
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              req_valid,
    input  logic [2:0]                        req_op,
    input  logic [16:0]                       req_page,
    input  logic [11:0]                       req_col,
    input  logic [$clog2(PAGE_BYTES+1)-1:0]   req_len,
    input  logic                              clr_err,
    output logic                              busy,
    output logic                              done,
    output logic                              err_rd_tmo,
    output logic                              err_wr_tmo,
    output logic                              err_prog,
    output logic                              err_erase,
    output logic [$clog2(PAGE_BYTES)-1:0]     buf_addr,
    output logic [7:0]                        buf_wdata,
    output logic                              buf_we,
    input  logic [7:0]                        buf_rdata,
    output logic                              dev_ce_n,
    output logic                              dev_cle,
    output logic                              dev_ale,
    output logic                              dev_we_n,
    output logic                              dev_re_n,
    output logic [7:0]                        dev_io_out,
    output logic                              dev_io_oe,
    input  logic [7:0]                        dev_io_in,
    input  logic                              dev_rb
);
    localparam int LEN_W  = $clog2(PAGE_BYTES + 1);
    localparam int ADDR_W = $clog2(PAGE_BYTES);

    typedef enum logic [3:0] {
        S_IDLE, S_CMD1, S_ADDR, S_WDATA, S_CMD2, S_WAIT_RB,
        S_RDATA, S_STAT_CMD, S_STAT_RD, S_FINISH
    } seq_st_e;

    seq_st_e st, st_nx;

    op_e              op_q;
    logic [ROW_W-1:0] page_q;
    logic [COL_W-1:0] col_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] idx;
    logic             issued;
    logic             rb_q;
    logic             rb_rise;

    logic             eng_start;
    bus_kind_e        eng_kind;
    logic [7:0]       eng_byte;
    logic             eng_done;
    logic [7:0]       eng_rbyte;
    logic [7:0]       addr_byte;
    logic             tmo_expired;

    logic [7:0]       first_code, second_code;
    logic [2:0]       addr_first, addr_last;
    logic [LEN_W-1:0] data_len;
    logic             byte_state;
    logic             addr_end, data_end;
    logic             set_rd_tmo, set_wr_tmo, set_prog, set_erase;
    logic             stat_bad;

    nand_addr_map u_addr (
        .page      (page_q),
        .col       (col_q),
        .idx       (idx[2:0]),
        .addr_byte (addr_byte)
    );

    nand_wait_timer #(.LIMIT(TMO_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (st == S_WAIT_RB),
        .expired (tmo_expired)
    );

    nand_bus_engine #(.RD_LOW_CYC(RD_LOW_CYC)) u_eng (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (eng_start),
        .kind   (eng_kind),
        .wbyte  (eng_byte),
        .done   (eng_done),
        .rbyte  (eng_rbyte),
        .cle    (dev_cle),
        .ale    (dev_ale),
        .we_n   (dev_we_n),
        .re_n   (dev_re_n),
        .io_out (dev_io_out),
        .io_oe  (dev_io_oe),
        .io_in  (dev_io_in)
    );

    // Per-operation frame parameters
    always_comb begin
        first_code  = CODE_RESET;
        second_code = CODE_READ_GO;
        addr_first  = 3'd0;
        addr_last   = 3'd4;
        data_len    = len_q;
        unique case (op_q)
            OP_RESET:     first_code = CODE_RESET;
            OP_READ_ID: begin
                first_code = CODE_IDENT;
                addr_last  = 3'd0;
                data_len   = LEN_W'(ID_BYTES);
            end
            OP_PAGE_READ: begin
                first_code  = CODE_READ_SETUP;
                second_code = CODE_READ_GO;
            end
            OP_PROGRAM: begin
                first_code  = CODE_PROG_SETUP;
                second_code = CODE_PROG_GO;
            end
            OP_ERASE: begin
                first_code  = CODE_ERASE_SETUP;
                second_code = CODE_ERASE_GO;
                addr_first  = 3'd2;
            end
            default: first_code = CODE_RESET;
        endcase
    end

    assign addr_end = (idx == LEN_W'(addr_last));
    assign data_end = (idx == data_len - LEN_W'(1));
    assign stat_bad = !eng_rbyte[STAT_READY_BIT] || eng_rbyte[STAT_FAIL_BIT];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    // Next state
    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE:
                if (req_valid) st_nx = (req_op <= 3'd4) ? S_CMD1 : S_FINISH;
            S_CMD1:
                if (eng_done) st_nx = (op_q == OP_RESET) ? S_WAIT_RB : S_ADDR;
            S_ADDR:
                if (eng_done && addr_end) begin
                    if (op_q == OP_READ_ID)
                        st_nx = S_RDATA;
                    else if (op_q == OP_PROGRAM && len_q != '0)
                        st_nx = S_WDATA;
                    else
                        st_nx = S_CMD2;
                end
            S_WDATA:
                if (eng_done && data_end) st_nx = S_CMD2;
            S_CMD2:
                if (eng_done) st_nx = S_WAIT_RB;
            S_WAIT_RB:
                if (rb_rise) begin
                    if (op_q == OP_PROGRAM || op_q == OP_ERASE)
                        st_nx = S_STAT_CMD;
                    else if (op_q == OP_PAGE_READ && len_q != '0)
                        st_nx = S_RDATA;
                    else
                        st_nx = S_FINISH;
                end else if (tmo_expired) begin
                    st_nx = S_FINISH;
                end
            S_RDATA:
                if (eng_done && data_end) st_nx = S_FINISH;
            S_STAT_CMD:
                if (eng_done) st_nx = S_STAT_RD;
            S_STAT_RD:
                if (eng_done) st_nx = S_FINISH;
            S_FINISH:
                st_nx = S_IDLE;
            default:
                st_nx = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        byte_state = 1'b0;
        eng_kind   = BK_CMD;
        eng_byte   = 8'h00;
        unique case (st)
            S_CMD1:     begin byte_state = 1'b1; eng_byte = first_code; end
            S_ADDR:     begin byte_state = 1'b1; eng_kind = BK_ADDR;
                              eng_byte = (op_q == OP_READ_ID) ? 8'h00 : addr_byte; end
            S_WDATA:    begin byte_state = 1'b1; eng_kind = BK_WDATA; eng_byte = buf_rdata; end
            S_CMD2:     begin byte_state = 1'b1; eng_byte = second_code; end
            S_STAT_CMD: begin byte_state = 1'b1; eng_byte = CODE_STATUS; end
            S_RDATA,
            S_STAT_RD:  begin byte_state = 1'b1; eng_kind = BK_RDATA; end
            default:    byte_state = 1'b0;
        endcase
        eng_start  = byte_state && !issued;
        busy       = (st != S_IDLE);
        done       = (st == S_FINISH);
        dev_ce_n   = (st == S_IDLE);
        buf_addr   = idx[ADDR_W-1:0];
        buf_wdata  = eng_rbyte;
        buf_we     = (st == S_RDATA) && eng_done;
        set_rd_tmo = (st == S_WAIT_RB) && !rb_rise && tmo_expired &&
                     (op_q == OP_RESET || op_q == OP_PAGE_READ);
        set_wr_tmo = (st == S_WAIT_RB) && !rb_rise && tmo_expired &&
                     (op_q == OP_PROGRAM || op_q == OP_ERASE);
        set_prog   = (st == S_STAT_RD) && eng_done && stat_bad && (op_q == OP_PROGRAM);
        set_erase  = (st == S_STAT_RD) && eng_done && stat_bad && (op_q == OP_ERASE);
    end

    // Request capture, counters, ready edge, flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q       <= OP_RESET;
            page_q     <= '0;
            col_q      <= '0;
            len_q      <= '0;
            idx        <= '0;
            issued     <= 1'b0;
            rb_q       <= 1'b1;
            rb_rise    <= 1'b0;
            err_rd_tmo <= 1'b0;
            err_wr_tmo <= 1'b0;
            err_prog   <= 1'b0;
            err_erase  <= 1'b0;
        end else begin
            if (st == S_IDLE && req_valid) begin
                op_q   <= op_e'(req_op);
                page_q <= req_page;
                col_q  <= req_col;
                len_q  <= req_len;
            end

            if (st != st_nx) begin
                idx    <= (st_nx == S_ADDR) ? LEN_W'(addr_first) : '0;
                issued <= 1'b0;
            end else if (eng_done) begin
                idx    <= idx + LEN_W'(1);
                issued <= 1'b0;
            end else if (eng_start) begin
                issued <= 1'b1;
            end

            rb_q <= dev_rb;
            if (st == S_CMD1)            rb_rise <= 1'b0;
            else if (dev_rb && !rb_q)    rb_rise <= 1'b1;

            err_rd_tmo <= (err_rd_tmo && !clr_err) || set_rd_tmo;
            err_wr_tmo <= (err_wr_tmo && !clr_err) || set_wr_tmo;
            err_prog   <= (err_prog   && !clr_err) || set_prog;
            err_erase  <= (err_erase  && !clr_err) || set_erase;
        end
    end
endmodule

// File: rtl/nand_seq_chk.sv
module nand_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic clr_err,
    input logic busy,
    input logic done,
    input logic err_rd_tmo,
    input logic err_wr_tmo,
    input logic err_prog,
    input logic err_erase,
    input logic dev_ce_n,
    input logic dev_cle,
    input logic dev_ale,
    input logic dev_we_n,
    input logic dev_re_n,
    input logic [7:0] dev_io_out,
    input logic dev_io_oe
);
    logic [3:0] flags;
    assign flags = {err_rd_tmo, err_wr_tmo, err_prog, err_erase};

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    // R2
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));

    // R11
    sticky_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_err |=> ((flags & $past(flags)) == $past(flags)));

    // R11
    clear_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_err && !busy) |=> (flags == 4'b0000));

    // R12
    latch_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dev_cle && dev_ale));

    // R12
    we_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dev_we_n) |-> ($stable(dev_cle) && $stable(dev_ale) && $stable(dev_io_out)));

    // R12
    we_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_we_n) |-> ($stable(dev_cle) && $stable(dev_ale) && $stable(dev_io_out)));

    // R12
    strobe_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dev_we_n || !dev_re_n) |-> !dev_ce_n);

    // R12
    no_drive_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_re_n |-> !dev_io_oe);
endmodule

bind nand_seq nand_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .clr_err    (clr_err),
    .busy       (busy),
    .done       (done),
    .err_rd_tmo (err_rd_tmo),
    .err_wr_tmo (err_wr_tmo),
    .err_prog   (err_prog),
    .err_erase  (err_erase),
    .dev_ce_n   (dev_ce_n),
    .dev_cle    (dev_cle),
    .dev_ale    (dev_ale),
    .dev_we_n   (dev_we_n),
    .dev_re_n   (dev_re_n),
    .dev_io_out (dev_io_out),
    .dev_io_oe  (dev_io_oe)
);

// File: tb/nand_seq_tb.sv
module nand_seq_tb;
    localparam int PB  = 64;
    localparam int LW  = $clog2(PB + 1);
    localparam int AW  = $clog2(PB);
    localparam int TMO = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [2:0] req_op = '0;
    logic [16:0] req_page = '0;
    logic [11:0] req_col = '0;
    logic [LW-1:0] req_len = '0;
    logic clr_err = 1'b0;
    logic busy, done, err_rd_tmo, err_wr_tmo, err_prog, err_erase;
    logic [AW-1:0] buf_addr;
    logic [7:0] buf_wdata, buf_rdata;
    logic buf_we;
    logic dev_ce_n, dev_cle, dev_ale, dev_we_n, dev_re_n, dev_io_oe;
    logic [7:0] dev_io_out;
    logic [7:0] dev_io_in = 8'h00;
    logic dev_rb = 1'b1;

    always #10 clk = ~clk;

    nand_seq #(.PAGE_BYTES(PB), .RD_LOW_CYC(2), .TMO_CYC(TMO)) u_dut (.*);

    // page buffer
    logic [7:0] src_mem [PB];
    logic [7:0] dst_mem [PB];
    assign buf_rdata = src_mem[buf_addr];
    always @(posedge clk) if (buf_we) dst_mem[buf_addr] <= buf_wdata;

    // behavioural flash device
    int got [$];
    logic [7:0] last_code = 8'h00;
    logic [7:0] row_lo = 8'h00;
    int rd_i = 0;
    int addr_n = 0;
    int trig_cnt = 0;
    int trig_used = 0;
    int busy_len = 20;
    int busy_left = 0;
    logic [7:0] status_val = 8'h40;
    int bad12 = 0;
    logic cle_f = 1'b0, ale_f = 1'b0;

    function automatic logic [7:0] pat(int i, logic [7:0] r);
        return 8'(i * 3 + 17) ^ r;
    endfunction

    always @(negedge dev_we_n) begin cle_f = dev_cle; ale_f = dev_ale; end

    always @(posedge dev_we_n) if (dev_ce_n === 1'b0) begin
        if (dev_cle !== cle_f || dev_ale !== ale_f) bad12++;
        if (dev_cle) begin
            got.push_back(256 + int'(dev_io_out));
            last_code = dev_io_out; rd_i = 0; addr_n = 0;
            if (dev_io_out == 8'h30 || dev_io_out == 8'h10 ||
                dev_io_out == 8'hD0 || dev_io_out == 8'hFF) trig_cnt++;
        end else if (dev_ale) begin
            got.push_back(512 + int'(dev_io_out));
            if (addr_n == 2) row_lo = dev_io_out;
            addr_n++;
        end else begin
            got.push_back(768 + int'(dev_io_out));
        end
    end

    always @(negedge dev_re_n) if (dev_ce_n === 1'b0) begin
        case (last_code)
            8'h90:   dev_io_in = 8'(8'hA0 + rd_i);
            8'h30:   dev_io_in = pat(rd_i, row_lo);
            8'h70:   dev_io_in = status_val;
            default: dev_io_in = 8'h00;
        endcase
        rd_i++;
    end

    always @(posedge dev_re_n) if (dev_ce_n === 1'b0) got.push_back(1024);

    always @(negedge clk) begin
        if (trig_used != trig_cnt) begin
            trig_used = trig_cnt;
            if (busy_len > 0) begin dev_rb = 1'b0; busy_left = busy_len; end
        end else if (!dev_rb) begin
            busy_left--;
            if (busy_left <= 0) dev_rb = 1'b1;
        end
        if (rst_n && dev_cle && dev_ale) bad12++;
        if (rst_n && dev_io_oe && !dev_re_n) bad12++;
    end

    // bench bookkeeping
    int checks = 0;
    int errors = 0;
    int exp_q [$];
    logic [3:0] fl_done;
    int last_n;

    task automatic check(input bit ok, input string req, input string act, input string expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%s expected=%s", req, act, expv);
        end
    endtask

    task automatic e(input int v); exp_q.push_back(v); endtask

    task automatic check_log(input string req);
        bit ok = (got.size() == exp_q.size());
        int at = -1;
        for (int i = 0; i < exp_q.size() && i < got.size(); i++)
            if (ok && got[i] != exp_q[i]) begin ok = 0; at = i; end
        if (!ok && at < 0) at = (got.size() < exp_q.size()) ? got.size() : exp_q.size();
        check(ok, req,
              $sformatf("%0d entries, item %0d = %h", got.size(), at,
                        (at >= 0 && at < got.size()) ? got[at] : -1),
              $sformatf("%0d entries, item %0d = %h", exp_q.size(), at,
                        (at >= 0 && at < exp_q.size()) ? exp_q[at] : -1));
    endtask

    task automatic run_op(input int op, input int page, input int col, input int len,
                          input bit poke, input string req);
        bit prof_ok = 1;
        int n = 0;
        got.delete();
        @(negedge clk);
        req_op = 3'(op); req_page = 17'(page); req_col = 12'(col); req_len = LW'(len);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (done !== 1'b1 && n < 5000) begin
            if (busy !== 1'b1 || dev_ce_n !== 1'b0) prof_ok = 0;
            if (poke && n == 3) begin req_valid = 1'b1; req_op = 3'd4; end
            if (poke && n == 4) req_valid = 1'b0;
            @(negedge clk);
            n++;
        end
        if (busy !== 1'b1) prof_ok = 0;
        fl_done = {err_rd_tmo, err_wr_tmo, err_prog, err_erase};
        last_n = n;
        @(negedge clk);
        if (busy !== 1'b0 || done !== 1'b0 || dev_ce_n !== 1'b1) prof_ok = 0;
        check(prof_ok, {"R2 busy/done profile ", req}, $sformatf("bad after %0d cycles", n),
              "busy high to single done, then idle");
    endtask

    task automatic push_addr5(input int page, input int col);
        e(512 + (col & 8'hFF)); e(512 + ((col >> 8) & 4'hF));
        e(512 + (page & 8'hFF)); e(512 + ((page >> 8) & 8'hFF)); e(512 + ((page >> 16) & 1));
    endtask

    task automatic wait_ready();
        int k = 0;
        while (dev_rb !== 1'b1 && k < 5000) begin @(negedge clk); k++; end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < PB; i++) begin src_mem[i] = 8'(i * 5 + 3); dst_mem[i] = 8'h00; end
        repeat (3) @(negedge clk);
        // R1 reset state
        check(busy === 1'b0 && done === 1'b0 && dev_ce_n === 1'b1 && dev_we_n === 1'b1 &&
              dev_re_n === 1'b1 && {err_rd_tmo, err_wr_tmo, err_prog, err_erase} === 4'b0,
              "R1 reset state", $sformatf("busy=%b done=%b ce=%b", busy, done, dev_ce_n), "idle");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R8 reset op
        busy_len = 20;
        run_op(0, 0, 0, 0, 0, "R8");
        exp_q.delete(); e(256 + 8'hFF); check_log("R8 reset sequence");
        check(fl_done == 4'b0, "R8 flags", $sformatf("%b", fl_done), "0000");

        // R7 read ID
        run_op(1, 0, 0, 0, 0, "R7");
        exp_q.delete(); e(256 + 8'h90); e(512); for (int i = 0; i < 5; i++) e(1024);
        check_log("R7 read ID sequence");
        begin
            bit ok = 1;
            for (int i = 0; i < 5; i++) if (dst_mem[i] !== 8'(8'hA0 + i)) ok = 0;
            check(ok, "R7 ID bytes", $sformatf("%h %h", dst_mem[0], dst_mem[4]), "a0 a4");
        end

        // R3 R4 page read
        run_op(2, 17'h1A5C3, 12'h9B7, 16, 0, "R4");
        exp_q.delete(); e(256 + 8'h00); push_addr5(17'h1A5C3, 12'h9B7); e(256 + 8'h30);
        for (int i = 0; i < 16; i++) e(1024);
        check_log("R3 R4 page read sequence");
        begin
            bit ok = 1;
            for (int i = 0; i < 16; i++) if (dst_mem[i] !== pat(i, 8'hC3)) ok = 0;
            check(ok, "R4 page data", $sformatf("%h", dst_mem[15]), $sformatf("%h", pat(15, 8'hC3)));
        end

        // R2 request while busy ignored
        run_op(2, 17'h00042, 12'h001, 4, 1, "R2 poke");
        exp_q.delete(); e(256 + 8'h00); push_addr5(17'h00042, 12'h001); e(256 + 8'h30);
        for (int i = 0; i < 4; i++) e(1024);
        check_log("R2 request while busy ignored");

        // R5 program pass
        status_val = 8'h40;
        run_op(3, 17'h01234, 12'h000, 8, 0, "R5");
        exp_q.delete(); e(256 + 8'h80); push_addr5(17'h01234, 0);
        for (int i = 0; i < 8; i++) e(768 + int'(src_mem[i]));
        e(256 + 8'h10); e(256 + 8'h70); e(1024);
        check_log("R5 program sequence");
        check(fl_done == 4'b0, "R5 R9 program pass flags", $sformatf("%b", fl_done), "0000");

        // R9 program fail bit
        status_val = 8'h41;
        run_op(3, 17'h00007, 12'h020, 2, 0, "R9");
        check(fl_done == 4'b0010, "R9 program fail sets err_prog", $sformatf("%b", fl_done), "0010");

        // R6 erase pass, R11 sticky
        status_val = 8'h40;
        run_op(4, 17'h1FFFF, 12'h5A5, 0, 0, "R6");
        exp_q.delete(); e(256 + 8'h60); e(512 + 8'hFF); e(512 + 8'hFF); e(512 + 1);
        e(256 + 8'hD0); e(256 + 8'h70); e(1024);
        check_log("R6 erase sequence");
        check(fl_done == 4'b0010, "R11 err_prog sticky over erase", $sformatf("%b", fl_done), "0010");

        // R9 erase not ready
        status_val = 8'h00;
        run_op(4, 17'h00100, 0, 0, 0, "R9 erase");
        check(fl_done == 4'b0011, "R9 erase not-ready sets err_erase", $sformatf("%b", fl_done), "0011");
        status_val = 8'h40;

        // R11 clear
        @(negedge clk); clr_err = 1'b1;
        @(negedge clk); clr_err = 1'b0;
        check({err_rd_tmo, err_wr_tmo, err_prog, err_erase} == 4'b0, "R11 clear flags",
              $sformatf("%b", {err_rd_tmo, err_wr_tmo, err_prog, err_erase}), "0000");

        // R10 program timeout
        busy_len = 1000;
        run_op(3, 17'h00055, 0, 2, 0, "R10 wr");
        exp_q.delete(); e(256 + 8'h80); push_addr5(17'h00055, 0);
        e(768 + int'(src_mem[0])); e(768 + int'(src_mem[1])); e(256 + 8'h10);
        check_log("R10 no status read after timeout");
        check(fl_done == 4'b0100, "R10 program timeout sets err_wr_tmo", $sformatf("%b", fl_done), "0100");
        wait_ready();

        // R10 reset timeout (no ready edge)
        busy_len = 0;
        run_op(0, 0, 0, 0, 0, "R10 rd");
        check(fl_done == 4'b1100, "R10 reset timeout sets err_rd_tmo", $sformatf("%b", fl_done), "1100");
        check(last_n >= TMO, "R10 timeout not early", $sformatf("%0d", last_n), $sformatf(">=%0d", TMO));
        busy_len = 20;

        // R13 unknown op
        run_op(7, 0, 0, 0, 0, "R13");
        exp_q.delete(); check_log("R13 no bus cycles");
        check(last_n == 0, "R13 immediate done", $sformatf("%0d", last_n), "0");

        // R12 bus timing monitors
        check(bad12 == 0, "R12 strobe/latch timing", $sformatf("%0d violations", bad12), "0");

        finish_run();
    end
endmodule